// File: doc/BRIEF.md
# Priority Round-Robin Cell Arbiter

This unit decides, once per frame, which input lane of a four-by-four cell switch may drive each output. A frame begins with a one-cycle frame-start pulse. After the pulse, every input lane presents the first byte of its cell, the routing header, in the same cycle. That cycle is not known ahead of time and is recognised as the first cycle after frame start in which any lane shows its active flag. The unit decodes every header, resolves contention per output, and registers the result one cycle later. The result is a per-output 2-bit grant naming the winning input, a per-output disable line, and a per-input won flag.

Contention on an output is settled in two stages. Active cells that carry the priority flag are considered first. Only when none of them targets that output do the ordinary cells compete. Within whichever group competes, the winner is the first requester found when scanning upward, with wraparound, from the input just after the one that last held the output. That pointer is the stored grant itself, so it advances only in frames where the output is requested. From frame start until the header has been taken, every output is disabled, so the data and acknowledgement paths can drive their defaults. After the header, outputs that nobody requested stay disabled.

Top module: `cell_arbiter`

## Requirements
- R1: Each lane byte is decoded as follows: bit 0 is the active flag, bit 1 is the priority flag, and bits 3:2 give the destination output index. Bits 7:4 have no effect, and a byte whose bit 0 is clear requests nothing, whatever its other bits hold.
- R2: While rst_n is low, every grant is 0, every out_disable bit is 1 and every in_won bit is 0.
- R3: The cycle after frame_start is sampled high, all out_disable bits are 1 and all in_won bits are 0, and the grants keep their previous values.
- R4: In the first cycle after frame start in which any lane has its active bit set, the headers are taken. This can happen any number of cycles after the pulse. One cycle later, each requested output shows its winner's index on grant[o] with out_disable[o] low, and each unrequested output keeps its grant with out_disable[o] high.
- R5: An active cell with the priority flag set wins over every active cell without it that targets the same output.
- R6: Among contenders of equal rank, output o goes to the first requester in the order grant[o]+1, grant[o]+2, grant[o]+3, grant[o] (modulo 4), where grant[o] is the stored grant from the last frame that requested o.
- R7: in_won[i] is 1 exactly when input i won the output it requested in the current frame. The number of won flags that are set always equals the number of outputs with out_disable low.
- R8: A frame in which no lane raises its active bit changes no grant, and it leaves all outputs disabled and all won flags clear.
- R9: Once the headers of a frame have been taken, later bytes with the active bit set in the same frame have no effect until the next frame_start.
- R10: If frame_start and an active header arrive in the same cycle, the header is ignored and the new frame waits for a later header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| lane_hdr | input | 4x8 | Byte lanes from the four inputs; lane i at [i] |
| grant | output | 4x2 | Per-output index of the granted input; output o at [o] |
| out_disable | output | 4 | Per-output disable; high until arbitration completes or when unrequested |
| in_won | output | 4 | Per-input flag, high when that input won its requested output |

## Verification
The table first sends all four inputs to one output for four frames in a row. This separates a true rotating pointer from a fixed-order or stuck pointer, and it shows the wrap from input 3 back to input 0. Mixed frames follow. One places a single priority requester among ordinary ones, one places two priority requesters that must rotate among themselves, and one sends each input to a different output with the spare header bits set. These tell apart the two-stage ranking, the independence of the per-output pointers, and correct field decoding. Inactive frames, including frames whose lanes carry nonzero bytes with the active flag clear, show that nothing moves without an active flag. Varying the gap between the pulse and the header, and sending a second active byte late in a frame, show that only the first active cycle of each frame is taken.

// File: rtl/cellarb_pkg.sv
package cellarb_pkg;
  // Header field positions; neighbours decode the same byte layout.
  localparam int unsigned HDR_ACT_BIT = 0;
  localparam int unsigned HDR_PRI_BIT = 1;
  localparam int unsigned HDR_DST_LO  = 2;
endpackage

// File: rtl/cellarb_hdr_decode.sv
module cellarb_hdr_decode
  import cellarb_pkg::*;
#(
  parameter  int N_PORTS = 4,
  parameter  int LANE_W  = 8,
  localparam int IDX_W   = $clog2(N_PORTS),
  localparam int FLD_TOP = HDR_DST_LO + IDX_W
) (
  input  logic [N_PORTS-1:0][LANE_W-1:0] lane_hdr,
  output logic [N_PORTS-1:0]             act,
  output logic [N_PORTS-1:0]             pri,
  output logic [N_PORTS-1:0][IDX_W-1:0]  dst
);
  logic [N_PORTS-1:0] unused_spare;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_lane
    assign act[i]          = lane_hdr[i][HDR_ACT_BIT];
    assign pri[i]          = lane_hdr[i][HDR_PRI_BIT];
    assign dst[i]          = lane_hdr[i][FLD_TOP-1:HDR_DST_LO];
    assign unused_spare[i] = ^lane_hdr[i][LANE_W-1:FLD_TOP];
  end
endmodule

// File: rtl/cellarb_rr_pick.sv
module cellarb_rr_pick #(
  parameter  int N_PORTS = 4,
  localparam int IDX_W   = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] req,
  input  logic [N_PORTS-1:0] req_hi,
  input  logic [IDX_W-1:0]   last,
  output logic               found,
  output logic [IDX_W-1:0]   winner
);
  logic [N_PORTS-1:0] cand;

  always_comb begin
    cand   = (|req_hi) ? req_hi : req;
    found  = 1'b0;
    winner = '0;
    // Walk from the farthest slot to the nearest so the nearest hit wins.
    for (int k = N_PORTS; k >= 1; k--) begin
      int j;
      j = (int'(last) + k) % N_PORTS;
      if (cand[j]) begin
        found  = 1'b1;
        winner = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/cellarb_frame_seq.sv
module cellarb_frame_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic any_active,
  output logic hdr_take
);
  logic armed_q;
  logic armed_d;

  assign hdr_take = armed_q & any_active & ~frame_start;

  always_comb begin
    armed_d = armed_q;
    if (frame_start)   armed_d = 1'b1;
    else if (hdr_take) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/cell_arbiter.sv
module cell_arbiter #(
  parameter  int N_PORTS = 4,
  parameter  int LANE_W  = 8,
  localparam int IDX_W   = $clog2(N_PORTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            frame_start,
  input  logic [N_PORTS-1:0][LANE_W-1:0]  lane_hdr,
  output logic [N_PORTS-1:0][IDX_W-1:0]   grant,
  output logic [N_PORTS-1:0]              out_disable,
  output logic [N_PORTS-1:0]              in_won
);
  logic [N_PORTS-1:0]             act;
  logic [N_PORTS-1:0]             pri;
  logic [N_PORTS-1:0][IDX_W-1:0]  dst;
  logic                           hdr_take;

  logic [N_PORTS-1:0][N_PORTS-1:0] req;
  logic [N_PORTS-1:0][N_PORTS-1:0] req_hi;
  logic [N_PORTS-1:0]              found;
  logic [N_PORTS-1:0][IDX_W-1:0]   winner;

  logic [N_PORTS-1:0][IDX_W-1:0]   grant_q, grant_d;
  logic [N_PORTS-1:0]              dis_q, dis_d;
  logic [N_PORTS-1:0]              won_q, won_d;
  logic                            upd_en;

  cellarb_hdr_decode #(.N_PORTS(N_PORTS), .LANE_W(LANE_W)) u_dec (
    .lane_hdr (lane_hdr),
    .act      (act),
    .pri      (pri),
    .dst      (dst)
  );

  cellarb_frame_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .any_active  (|act),
    .hdr_take    (hdr_take)
  );

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
      assign req[o][i]    = act[i] && (dst[i] == IDX_W'(o));
      assign req_hi[o][i] = req[o][i] && pri[i];
    end

    cellarb_rr_pick #(.N_PORTS(N_PORTS)) u_pick (
      .req    (req[o]),
      .req_hi (req_hi[o]),
      .last   (grant_q[o]),
      .found  (found[o]),
      .winner (winner[o])
    );
  end

  assign upd_en = frame_start | hdr_take;

  always_comb begin
    grant_d = grant_q;
    dis_d   = dis_q;
    won_d   = won_q;
    if (frame_start) begin
      dis_d = '1;
      won_d = '0;
    end else if (hdr_take) begin
      won_d = '0;
      for (int o = 0; o < N_PORTS; o++) begin
        dis_d[o] = ~found[o];
        if (found[o]) begin
          grant_d[o]          = winner[o];
          won_d[int'(winner[o])] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      dis_q   <= '1;
      won_q   <= '0;
    end else if (upd_en) begin
      grant_q <= grant_d;
      dis_q   <= dis_d;
      won_q   <= won_d;
    end
  end

  assign grant       = grant_q;
  assign out_disable = dis_q;
  assign in_won      = won_q;
endmodule

// File: rtl/cellarb_chk.sv
module cellarb_chk #(
  parameter int N_PORTS = 4,
  parameter int IDX_W   = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           frame_start,
  input logic                           hdr_take,
  input logic [N_PORTS-1:0][IDX_W-1:0]  grant,
  input logic [N_PORTS-1:0]             out_disable,
  input logic [N_PORTS-1:0]             in_won
);
  AST_FS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ((&out_disable) && (in_won == '0))); // R3

  AST_GRANT_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grant) |-> $past(hdr_take)); // R8

  AST_ENABLE_ONLY_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(out_disable) & ~out_disable)) |-> $past(hdr_take)); // R4

  AST_WON_MATCHES_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_won) == $countones(~out_disable)); // R7

  AST_WON_RISE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~$past(in_won) & in_won)) |-> $past(hdr_take)); // R7

  AST_ONE_TAKE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> !hdr_take); // R9
endmodule

bind cell_arbiter cellarb_chk #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .hdr_take    (hdr_take),
  .grant       (grant),
  .out_disable (out_disable),
  .in_won      (in_won)
);

// File: tb/cell_arbiter_test.sv
module cell_arbiter_test;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame_start;
  logic [3:0][7:0]  lane_hdr;
  logic [3:0][1:0]  grant;
  logic [3:0]       out_disable;
  logic [3:0]       in_won;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cell_arbiter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .lane_hdr    (lane_hdr),
    .grant       (grant),
    .out_disable (out_disable),
    .in_won      (in_won)
  );

  // {lanes 3..0, idle gap, expected grant, expected disable, expected won}
  localparam int NV = 10;
  localparam logic [50:0] VECS [NV] = '{
    {32'h01010101, 3'd0, 8'h01, 4'b1110, 4'b0010},  // R6 all to out0, ptr 0 -> 1
    {32'h01010101, 3'd2, 8'h02, 4'b1110, 4'b0100},  // R6 -> 2
    {32'h01010101, 3'd5, 8'h03, 4'b1110, 4'b1000},  // R6 -> 3
    {32'h01010101, 3'd1, 8'h00, 4'b1110, 4'b0001},  // R6 wrap -> 0
    {32'h09070505, 3'd3, 8'h38, 4'b1001, 4'b1100},  // R5 single priority on out1
    {32'h07050507, 3'd0, 8'h3C, 4'b1101, 4'b1000},  // R5 R6 two priority, from 3
    {32'h07050507, 3'd4, 8'h30, 4'b1101, 4'b0001},  // R5 R6 rotate to 0
    {32'hF1F5F9FD, 3'd1, 8'h1B, 4'b0000, 4'b1111},  // R1 spare bits, all distinct
    {32'h0C0E0C0E, 3'd2, 8'h1B, 4'b1111, 4'b0000},  // R8 R1 inactive bytes
    {32'h01010E0C, 3'd0, 8'h1A, 4'b1110, 4'b0100}   // R1 inactive lanes skipped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] hdr, input int idle, input logic [7:0] prev_g);
    @(negedge clk);
    frame_start = 1'b1;
    lane_hdr    = '0;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R3 disable after start", 32'(out_disable), 32'hF);
    chk("R3 won cleared",         32'(in_won),      32'h0);
    chk("R3 grant held",          32'(grant),       32'(prev_g));
    repeat (idle) @(negedge clk);
    lane_hdr = hdr;
    @(negedge clk);
    lane_hdr = '0;
  endtask

  task automatic check_out(input string tag, input logic [7:0] g,
                           input logic [3:0] d, input logic [3:0] w);
    chk({tag, " grant"},   32'(grant),       32'(g));
    chk({tag, " disable"}, 32'(out_disable), 32'(d));
    chk({tag, " won"},     32'(in_won),      32'(w));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] g_prev;
    rst_n       = 1'b0;
    frame_start = 1'b0;
    lane_hdr    = '0;
    repeat (3) @(negedge clk);
    check_out("R2 reset", 8'h00, 4'hF, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);

    g_prev = 8'h00;
    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v][50:19], int'(VECS[v][18:16]), g_prev);
      check_out($sformatf("R4 vector %0d", v), VECS[v][15:8], VECS[v][7:4], VECS[v][3:0]);
      g_prev = VECS[v][15:8];
    end

    // R9: a later active byte in the same frame is ignored
    run_frame(32'h01010101, 1, 8'h1A);
    check_out("R6 ptr 2 -> 3", 8'h1B, 4'b1110, 4'b1000);
    lane_hdr = 32'h0F0F0F0F;
    repeat (2) @(negedge clk);
    lane_hdr = '0;
    @(negedge clk);
    check_out("R9 late active ignored", 8'h1B, 4'b1110, 4'b1000);

    // R10: header coinciding with frame_start is not taken
    @(negedge clk);
    frame_start = 1'b1;
    lane_hdr    = 32'h01010101;
    @(negedge clk);
    frame_start = 1'b0;
    lane_hdr    = '0;
    @(negedge clk);
    check_out("R10 header at start ignored", 8'h1B, 4'hF, 4'h0);
    lane_hdr = 32'h05050505;
    @(negedge clk);
    lane_hdr = '0;
    check_out("R10 later header taken", 8'h1F, 4'b1101, 4'b1000);

    // R2: reset mid-run restores pointers
    rst_n = 1'b0;
    @(negedge clk);
    check_out("R2 mid-run reset", 8'h00, 4'hF, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(32'h01010101, 0, 8'h00);
    check_out("R6 pointer restarted", 8'h01, 4'b1110, 4'b0010);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule